// File: doc/BRIEF.md
# Serial Peripheral Control and Status Register Bank

This block is the software-visible register bank that sits between a bus master and the core of a serial transmit/receive peripheral. The master reaches it through a slave port with separate write and read channels. Each channel uses a request/acknowledge handshake. The bank holds configuration fields: enable, baud divisor, character length and parity mode. It drives these fields to the peripheral core. It also holds a one-entry transmit holding register that the core drains. It captures received characters and mirrors the core's busy flags. Event inputs from the core are gathered into a sticky interrupt source register, and the bank drives one masked interrupt line.

Every register uses one of four access behaviours. Read-write registers return what was last written. Read-only registers ignore writes but still acknowledge them. A write-1-to-clear register and a write-1-to-set register both act on the interrupt sources. Registers sit on 32-bit word offsets. Address bits [1:0] must be zero for an access to hit a register. Any other address is treated as an unused offset.

Top module: `serial_csr_bank`

## Requirements
- R1: After reset the bank holds these values: enable 0, interrupt mask 0, baud divisor 434, character length 8, parity 0, interrupt sources 0, transmit holding empty. The outputs irq and rd_ack are 0.
- R2: The read-write registers read back the written value, masked to their field width. These are enable at 0x08 (bit 0), interrupt mask at 0x0C (bits 3:0), baud divisor at 0x10 (bits 15:0) and character length at 0x14 (bits 3:0). Unimplemented bits read 0.
- R3: rd_ack rises on the clock edge that follows the first cycle of rd_req, and rd_data is valid in that same cycle. rd_ack lasts one cycle and is never high in two consecutive cycles.
- R4: For every write that does not target a full transmit holding register, wr_ack is high in the same cycle as wr_req. The write takes effect at the clock edge that ends that cycle.
- R5: A write to 0x00 loads the holding register: tx_valid goes high and tx_byte carries the low 8 data bits. While tx_valid is high and tx_take is low, a write to 0x00 is not acknowledged and the held byte is kept. The write is acknowledged in the cycle that tx_take is high. tx_take with no pending write empties the register.
- R6: Writes to the read-only offsets are acknowledged and change nothing. These offsets are 0x04 (received character), 0x1C (bit 0 = tx_busy) and 0x20 (bit 0 = rx_busy).
- R7: The interrupt source register at 0x24 has one bit per event. An event pulse sets its bit, and the bit stays set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear of the same bit leaves the bit set.
- R8: Writing 1s to 0x28 sets the matching source bits, and 0s have no effect. 0x28 always reads as 0.
- R9: irq is high exactly when some bit is set in both the source register and the mask register.
- R10: Reads of unused or misaligned offsets return 0. Writes to them are acknowledged and change no register.
- R11: Parity at 0x18 (bits 1:0) takes 0 = none, 1 = odd, 2 = even. A write of 3 is acknowledged and leaves the previous setting.
- R12: cfg_enable, cfg_baud, cfg_len and cfg_parity always equal the contents of the matching registers.
- R13: When rx_valid is high, rx_byte is captured and reads back at 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request, held until acknowledged |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| wr_ack | output | 1 | Write acknowledge (same cycle unless stalled) |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, valid with rd_ack |
| rd_ack | output | 1 | Read acknowledge pulse |
| cfg_enable | output | 1 | Peripheral enable |
| cfg_baud | output | 16 | Baud divisor |
| cfg_len | output | 4 | Character length |
| cfg_parity | output | 2 | Parity mode |
| tx_valid | output | 1 | Holding register holds a byte |
| tx_byte | output | 8 | Held transmit byte |
| tx_take | input | 1 | Core takes the held byte |
| tx_busy | input | 1 | Transmitter busy flag |
| rx_busy | input | 1 | Receiver busy flag |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| evt | input | 4 | Interrupt event pulses from the core |
| irq | output | 1 | Masked interrupt output |

## Verification
Two situations are hard to reach from the ports. The first is a write-1-to-clear that meets a hardware event on the same bit in the same cycle. The bench reaches it by driving the write request and the event pulse on the same falling edge, then reads the source register back. The second is a transmit write that stalls behind a full holding register. The bench holds the write request for several cycles while tx_take stays low, then raises tx_take while the request is still pending. It checks that the acknowledge appears in that cycle and that the new byte replaces the old one at the same edge. The mask logic is checked by sweeping all 256 source/mask pairs.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

    localparam int BUS_W = 32;

    // word indices (byte offset / 4)
    localparam int IDX_TXD  = 0;
    localparam int IDX_RXD  = 1;
    localparam int IDX_EN   = 2;
    localparam int IDX_MASK = 3;
    localparam int IDX_BAUD = 4;
    localparam int IDX_LEN  = 5;
    localparam int IDX_PAR  = 6;
    localparam int IDX_TXST = 7;
    localparam int IDX_RXST = 8;
    localparam int IDX_SRC  = 9;
    localparam int IDX_SET  = 10;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2
    } parity_e;

    typedef enum logic [1:0] {
        ACC_RW,
        ACC_RO,
        ACC_W1S,
        ACC_W1C
    } access_e;

    // one-hot style write targets
    typedef struct packed {
        logic txd;
        logic en;
        logic mask;
        logic baud;
        logic len;
        logic par;
        logic src_clr;
        logic src_set;
    } wr_sel_t;

    function automatic access_e access_of(input int idx);
        case (idx)
            IDX_RXD, IDX_TXST, IDX_RXST: return ACC_RO;
            IDX_SRC:                     return ACC_W1C;
            IDX_SET:                     return ACC_W1S;
            default:                     return ACC_RW;
        endcase
    endfunction

    function automatic wr_sel_t decode_sel(input int idx, input logic aligned);
        wr_sel_t s;
        s = '0;
        if (aligned && access_of(idx) != ACC_RO) begin
            case (idx)
                IDX_TXD:  s.txd     = 1'b1;
                IDX_EN:   s.en      = 1'b1;
                IDX_MASK: s.mask    = 1'b1;
                IDX_BAUD: s.baud    = 1'b1;
                IDX_LEN:  s.len     = 1'b1;
                IDX_PAR:  s.par     = 1'b1;
                IDX_SRC:  s.src_clr = 1'b1;
                IDX_SET:  s.src_set = 1'b1;
                default:  s         = '0;
            endcase
        end
        return s;
    endfunction

    function automatic logic parity_legal(input logic [1:0] v);
        return (v == PAR_NONE) || (v == PAR_ODD) || (v == PAR_EVEN);
    endfunction

endpackage

// File: rtl/csr_tx_holding.sv
module csr_tx_holding #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (load) begin
            full <= 1'b1;
            data <= load_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R5: the write channel must never load over an unconsumed byte
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |-> !load);

    // R5: a held byte stays put until taken
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(data)));

endmodule

// File: rtl/csr_irq_ctrl.sv
module csr_irq_ctrl #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] clr_bits,
    input  logic [NUM_EVT-1:0] set_bits,
    input  logic [NUM_EVT-1:0] mask,
    output logic [NUM_EVT-1:0] src,
    output logic               irq
);

    logic [NUM_EVT-1:0] pending;

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                src[k] <= 1'b0;
            else if (evt[k] || set_bits[k])
                src[k] <= 1'b1;
            else if (clr_bits[k])
                src[k] <= 1'b0;
        end
    end

    assign pending = src & mask;
    assign irq     = |pending;

    // R7: an event always leaves its bit set, even against a clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((src & $past(evt)) == $past(evt)));

    // R7: a clear with no competing set empties the bit
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits & ~evt & ~set_bits) != '0) |=>
        ((src & $past(clr_bits & ~evt & ~set_bits)) == '0));

    // R7: bits not cleared are sticky
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ((src & ~clr_bits) != '0) |=>
        ((src & $past(src & ~clr_bits)) == $past(src & ~clr_bits)));

    // R9: nothing unmasked means no interrupt
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux
    import serial_csr_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int CHAR_W  = 8,
    parameter int BAUD_W  = 16,
    parameter int LEN_W   = 4,
    parameter int NUM_EVT = 4
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic               aligned,
    input  logic [CHAR_W-1:0]  txd,
    input  logic [CHAR_W-1:0]  rxd,
    input  logic               en,
    input  logic [NUM_EVT-1:0] mask,
    input  logic [BAUD_W-1:0]  baud,
    input  logic [LEN_W-1:0]   len,
    input  logic [1:0]         par,
    input  logic               tx_busy,
    input  logic               rx_busy,
    input  logic [NUM_EVT-1:0] src,
    output logic [BUS_W-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (int'(idx))
                IDX_TXD:  rdata[CHAR_W-1:0]  = txd;
                IDX_RXD:  rdata[CHAR_W-1:0]  = rxd;
                IDX_EN:   rdata[0]           = en;
                IDX_MASK: rdata[NUM_EVT-1:0] = mask;
                IDX_BAUD: rdata[BAUD_W-1:0]  = baud;
                IDX_LEN:  rdata[LEN_W-1:0]   = len;
                IDX_PAR:  rdata[1:0]         = par;
                IDX_TXST: rdata[0]           = tx_busy;
                IDX_RXST: rdata[0]           = rx_busy;
                IDX_SRC:  rdata[NUM_EVT-1:0] = src;
                default:  rdata              = '0;
            endcase
        end
    end

endmodule

// File: rtl/serial_csr_bank.sv
module serial_csr_bank
    import serial_csr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CHAR_W     = 8,
    parameter int BAUD_W     = 16,
    parameter int LEN_W      = 4,
    parameter int NUM_EVT    = 4,
    parameter int BAUD_RESET = 434,
    parameter int LEN_RESET  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_req,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    output logic               wr_ack,
    input  logic               rd_req,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BUS_W-1:0]   rd_data,
    output logic               rd_ack,
    output logic               cfg_enable,
    output logic [BAUD_W-1:0]  cfg_baud,
    output logic [LEN_W-1:0]   cfg_len,
    output logic [1:0]         cfg_parity,
    output logic               tx_valid,
    output logic [CHAR_W-1:0]  tx_byte,
    input  logic               tx_take,
    input  logic               tx_busy,
    input  logic               rx_busy,
    input  logic               rx_valid,
    input  logic [CHAR_W-1:0]  rx_byte,
    input  logic [NUM_EVT-1:0] evt,
    output logic               irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   wr_idx, rd_idx;
    logic               wr_aligned, rd_aligned;
    wr_sel_t            sel;
    logic               wr_fire;
    logic               hold_full;
    logic               en_q;
    logic [NUM_EVT-1:0] mask_q, src_q, clr_bits, set_bits;
    logic [BAUD_W-1:0]  baud_q;
    logic [LEN_W-1:0]   len_q;
    parity_e            par_q;
    logic [CHAR_W-1:0]  rxd_q;
    logic [BUS_W-1:0]   rd_val;

    // ---------------- write channel ----------------
    assign wr_idx     = wr_addr[ADDR_W-1:2];
    assign wr_aligned = (wr_addr[1:0] == 2'b00);

    always_comb sel = decode_sel(int'(wr_idx), wr_aligned);

    // only a transmit write may stall; it proceeds when the holding slot frees
    assign wr_ack  = wr_req && (!sel.txd || !hold_full || tx_take);
    assign wr_fire = wr_req && wr_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mask_q <= '0;
            baud_q <= BAUD_W'(BAUD_RESET);
            len_q  <= LEN_W'(LEN_RESET);
            par_q  <= PAR_NONE;
        end else if (wr_fire) begin
            if (sel.en)   en_q   <= wr_data[0];
            if (sel.mask) mask_q <= wr_data[NUM_EVT-1:0];
            if (sel.baud) baud_q <= wr_data[BAUD_W-1:0];
            if (sel.len)  len_q  <= wr_data[LEN_W-1:0];
            if (sel.par && parity_legal(wr_data[1:0]))
                par_q <= parity_e'(wr_data[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rxd_q <= '0;
        else if (rx_valid)
            rxd_q <= rx_byte;
    end

    assign clr_bits = (wr_fire && sel.src_clr) ? wr_data[NUM_EVT-1:0] : '0;
    assign set_bits = (wr_fire && sel.src_set) ? wr_data[NUM_EVT-1:0] : '0;

    csr_tx_holding #(.CHAR_W(CHAR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_fire && sel.txd),
        .load_data (wr_data[CHAR_W-1:0]),
        .take      (tx_take),
        .full      (hold_full),
        .data      (tx_byte)
    );

    csr_irq_ctrl #(.NUM_EVT(NUM_EVT)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_bits (clr_bits),
        .set_bits (set_bits),
        .mask     (mask_q),
        .src      (src_q),
        .irq      (irq)
    );

    // ---------------- read channel ----------------
    assign rd_idx     = rd_addr[ADDR_W-1:2];
    assign rd_aligned = (rd_addr[1:0] == 2'b00);

    csr_rd_mux #(
        .IDX_W   (IDX_W),
        .CHAR_W  (CHAR_W),
        .BAUD_W  (BAUD_W),
        .LEN_W   (LEN_W),
        .NUM_EVT (NUM_EVT)
    ) u_mux (
        .idx     (rd_idx),
        .aligned (rd_aligned),
        .txd     (tx_byte),
        .rxd     (rxd_q),
        .en      (en_q),
        .mask    (mask_q),
        .baud    (baud_q),
        .len     (len_q),
        .par     (par_q),
        .tx_busy (tx_busy),
        .rx_busy (rx_busy),
        .src     (src_q),
        .rdata   (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ack  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_ack <= rd_req && !rd_ack;
            if (rd_req && !rd_ack)
                rd_data <= rd_val;
        end
    end

    assign cfg_enable = en_q;
    assign cfg_baud   = baud_q;
    assign cfg_len    = len_q;
    assign cfg_parity = par_q;
    assign tx_valid   = hold_full;

    // R3: acknowledge only answers a request from the previous cycle
    assert_rd_ack_after_req_R3: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> $past(rd_req));

    // R3: acknowledge is a single-cycle pulse
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !rd_ack);

    // R11: the reserved parity code never reaches the core
    assert_parity_legal_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_parity != 2'b11);

    // R6: read-only targets never change configuration
    assert_ro_no_effect_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && wr_aligned && (int'(wr_idx) == IDX_RXST)) |=>
        ($stable(cfg_baud) && $stable(cfg_len) && $stable(cfg_enable)));

endmodule

// File: tb/serial_csr_bank_tb.sv
module serial_csr_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_req = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ack;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_ack;
    logic        cfg_enable;
    logic [15:0] cfg_baud;
    logic [3:0]  cfg_len;
    logic [1:0]  cfg_parity;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_take = 1'b0;
    logic        tx_busy = 1'b0;
    logic        rx_busy = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [3:0]  evt = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    serial_csr_bank u_dut (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack),
        .cfg_enable(cfg_enable), .cfg_baud(cfg_baud), .cfg_len(cfg_len),
        .cfg_parity(cfg_parity), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_take(tx_take), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .evt(evt), .irq(irq)
    );

    localparam logic [7:0] A_TXD = 8'h00, A_RXD = 8'h04, A_EN = 8'h08,
        A_MASK = 8'h0C, A_BAUD = 8'h10, A_LEN = 8'h14, A_PAR = 8'h18,
        A_TXST = 8'h1C, A_RXST = 8'h20, A_SRC = 8'h24, A_SET = 8'h28;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int waits);
        waits = 0;
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        #1;
        while (!wr_ack && waits < 1000) begin
            waits++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 wr_req = 1'b0;
    endtask

    task automatic wrq(input logic [7:0] a, input logic [31:0] d);
        int w;
        wr(a, d, w);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output int lat);
        lat = 0;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_ack && lat < 1000);
        d = rd_data;
        rd_req = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        int lat;
        rd(a, d, lat);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int lat, w;

        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 rd_ack", {31'b0, rd_ack}, 32'd0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
        rdchk("R1 en", A_EN, 32'd0);
        rdchk("R1 mask", A_MASK, 32'd0);
        rdchk("R1 baud", A_BAUD, 32'd434);
        rdchk("R1 len", A_LEN, 32'd8);
        rdchk("R1 parity", A_PAR, 32'd0);
        rdchk("R1 src", A_SRC, 32'd0);

        // R3 read latency is one cycle
        rd(A_BAUD, d, lat);
        chk("R3 latency", lat, 32'd1);
        chk("R3 data", d, 32'd434);
        @(negedge clk);
        chk("R3 pulse", {31'b0, rd_ack}, 32'd0);

        // R4 same-cycle acknowledge, R2 readback with width masking
        wr(A_BAUD, 32'h1234_ABCD, w);
        chk("R4 no wait", w, 32'd0);
        rdchk("R2 baud", A_BAUD, 32'h0000_ABCD);
        chk("R12 cfg_baud", {16'b0, cfg_baud}, 32'h0000_ABCD);
        wrq(A_EN, 32'hFFFF_FFFF);
        rdchk("R2 en", A_EN, 32'd1);
        chk("R12 cfg_enable", {31'b0, cfg_enable}, 32'd1);
        wrq(A_MASK, 32'hFFFF_FFF5);
        rdchk("R2 mask", A_MASK, 32'd5);
        for (int v = 0; v < 16; v++) begin
            wrq(A_LEN, 32'hFFFF_FFF0 | v);
            rdchk("R2 len sweep", A_LEN, v);
            chk("R12 cfg_len", {28'b0, cfg_len}, v);
        end

        // R11 parity settings and reserved code
        for (int v = 0; v < 3; v++) begin
            wrq(A_PAR, v);
            rdchk("R11 parity", A_PAR, v);
            chk("R12 cfg_parity", {30'b0, cfg_parity}, v);
        end
        wrq(A_PAR, 32'd3);
        rdchk("R11 reserved ignored", A_PAR, 32'd2);

        // R13 receive capture, R6 read-only behaviour
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h5A;
        @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
        rdchk("R13 rx capture", A_RXD, 32'h5A);
        wr(A_RXD, 32'hFF, w);
        chk("R6 ack", w, 32'd0);
        rdchk("R6 rxd kept", A_RXD, 32'h5A);
        tx_busy = 1'b1;
        wrq(A_TXST, 32'h0);
        rdchk("R6 tx state", A_TXST, 32'd1);
        tx_busy = 1'b0;
        rx_busy = 1'b1;
        wrq(A_RXST, 32'h0);
        rdchk("R6 rx state", A_RXST, 32'd1);
        rx_busy = 1'b0;
        rdchk("R6 rx state idle", A_RXST, 32'd0);
        rdchk("R6 baud untouched", A_BAUD, 32'h0000_ABCD);

        // R5 transmit holding and stall
        wrq(A_TXD, 32'hFFFF_FFA5);
        @(negedge clk);
        chk("R5 valid", {31'b0, tx_valid}, 32'd1);
        chk("R5 byte", {24'b0, tx_byte}, 32'hA5);
        wr_req = 1'b1; wr_addr = A_TXD; wr_data = 32'h3C;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R5 stalled", {31'b0, wr_ack}, 32'd0);
            @(negedge clk);
        end
        chk("R5 held byte", {24'b0, tx_byte}, 32'hA5);
        tx_take = 1'b1;
        #1 chk("R5 ack on take", {31'b0, wr_ack}, 32'd1);
        @(posedge clk);
        #1 wr_req = 1'b0; tx_take = 1'b0;
        @(negedge clk);
        chk("R5 new valid", {31'b0, tx_valid}, 32'd1);
        chk("R5 new byte", {24'b0, tx_byte}, 32'h3C);
        tx_take = 1'b1;
        @(posedge clk);
        #1 tx_take = 1'b0;
        @(negedge clk);
        chk("R5 drained", {31'b0, tx_valid}, 32'd0);
        wr(A_TXD, 32'h11, w);
        chk("R5 empty no wait", w, 32'd0);
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;

        // R7 event sets, sticky, W1C
        wrq(A_MASK, 32'd0);
        @(negedge clk); evt = 4'b0100;
        @(negedge clk); evt = 4'b0000;
        repeat (2) @(negedge clk);
        rdchk("R7 event sticky", A_SRC, 32'h4);
        wrq(A_SET, 32'hA);
        rdchk("R8 set", A_SRC, 32'hE);
        rdchk("R8 reads zero", A_SET, 32'h0);
        wrq(A_SRC, 32'h2);
        rdchk("R7 w1c one bit", A_SRC, 32'hC);
        wrq(A_SRC, 32'h0);
        rdchk("R7 zero no effect", A_SRC, 32'hC);
        wrq(A_SET, 32'h0);
        rdchk("R8 zero no effect", A_SRC, 32'hC);
        // R7 event in the clear cycle wins
        @(negedge clk);
        wr_req = 1'b1; wr_addr = A_SRC; wr_data = 32'hF; evt = 4'b1000;
        @(posedge clk);
        #1 wr_req = 1'b0; evt = 4'b0000;
        rdchk("R7 set wins", A_SRC, 32'h8);

        // R9 exhaustive source x mask sweep
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                wrq(A_SRC, 32'hF);
                wrq(A_SET, p);
                wrq(A_MASK, m);
                @(negedge clk);
                chk("R9 irq", {31'b0, irq}, {31'b0, ((p & m) != 0)});
            end
        end
        wrq(A_SRC, 32'hF);
        wrq(A_MASK, 32'h0);

        // R10 unused and misaligned offsets
        wrq(A_EN, 32'd0);
        for (int i = 11; i < 64; i++) begin
            wrq(8'(i * 4), 32'hFFFF_FFFF);
            rdchk("R10 unused read", 8'(i * 4), 32'd0);
        end
        wrq(8'h09, 32'hFFFF_FFFF);
        wrq(8'h13, 32'h0);
        rdchk("R10 misaligned write en", A_EN, 32'd0);
        rdchk("R10 misaligned write baud", A_BAUD, 32'h0000_ABCD);
        wrq(A_EN, 32'd1);
        rdchk("R10 misaligned read", 8'h0A, 32'd0);
        rdchk("R10 src untouched", A_SRC, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule